// File: doc/BRIEF.md
# Single-Step Bidirectional Word Shifter with End Fills

This block moves an n-bit data word by either zero or one bit position, toward the high end or toward the low end. The vacated end position is filled from one of two independent external bits: one that enters below bit 0 and one that enters above the top bit. An enable input gates the whole result, so that a disabled shifter drives an all-zero word.

The block is purely combinational. It has no clock and no reset, and its output follows its inputs within the same evaluation. Each output bit is a three-way multiplexer that chooses between its own input bit and the two neighbouring input bits. One shared decode of the control inputs drives the select lines, and the enable is folded into those lines. The block is meant to sit inside a datapath as one stage of a shift network, or as a serial-in shift step that feeds new bits in at either end.

Top module: `shift1_fill`

## Requirements
- R1: When `en` is 0, every bit of `dout` is 0, whatever the values of the other inputs.
- R2: When `en` is 1 and `shift_req` is 0, `dout[i]` equals `din[i]` for every i.
- R3: When `en` is 1, `shift_req` is 1 and `dir_right` is 0 (a shift toward higher indices), `dout[i]` equals `din[i-1]` for i from 1 to WIDTH-1.
- R4: When `en` is 1, `shift_req` is 1 and `dir_right` is 1 (a shift toward lower indices), `dout[i]` equals `din[i+1]` for i from 0 to WIDTH-2.
- R5: On a shift toward higher indices, `dout[0]` equals `fill_lo`.
- R6: On a shift toward lower indices, `dout[WIDTH-1]` equals `fill_hi`.
- R7: A fill bit has no effect on `dout` when the block is disabled or not shifting. On a shift, the fill bit at the end the word moves away from (`fill_hi` for a shift toward higher indices, `fill_lo` for a shift toward lower indices) has no effect on `dout` either.
- R8: `dout` reflects a change of any input within the same evaluation, with no clock edge in between.
- R9: `WIDTH` is a parameter with a default of 8 and a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | WIDTH | Data word to be shifted |
| fill_lo | input | 1 | Bit that enters at position 0 on a shift toward higher indices |
| fill_hi | input | 1 | Bit that enters at position WIDTH-1 on a shift toward lower indices |
| shift_req | input | 1 | 1 moves the word by one position; 0 passes it through unchanged |
| dir_right | input | 1 | Shift direction: 0 = toward higher indices, 1 = toward lower indices |
| en | input | 1 | Enable; 0 forces `dout` to zero |
| dout | output | WIDTH | Result word |

## Verification
On every shift, two functions act in the same evaluation. The bulk of the word moves, and a fill bit is inserted at the vacated end. At the same time, the enable can override both. The bench applies every data word together with all four fill combinations and all eight control combinations. Each result is compared against an independent bit-loop model, so each check judges the moved bits and the inserted end bit together. Directed scenarios then hold the word fixed and toggle only one fill bit, or only the enable. This shows that the fill bit on the far end, and the fill bits in pass-through or disabled mode, do not change the output.

// File: rtl/shift1_fill.sv
module shift1_fill #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] din,
  input  logic             fill_lo,
  input  logic             fill_hi,
  input  logic             shift_req,
  input  logic             dir_right,
  input  logic             en,
  output logic [WIDTH-1:0] dout
);

  localparam int EXT_W = WIDTH + 2;

  logic [EXT_W-1:0] ext;
  logic             sel_hold;
  logic             sel_up;
  logic             sel_down;

  // Word padded by its fills: ext[0] stands for din[-1], ext[WIDTH+1] for din[WIDTH].
  assign ext      = {fill_hi, din, fill_lo};
  assign sel_hold = en & ~shift_req;
  assign sel_up   = en & shift_req & ~dir_right;
  assign sel_down = en & shift_req & dir_right;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dout[i] = (sel_hold & ext[i+1]) | (sel_up & ext[i]) | (sel_down & ext[i+2]);
  end

  always_comb begin
    if (!en) begin
      assert_off_zero_R1: assert (dout == '0);
    end
    if (en && !shift_req) begin
      assert_pass_R2: assert (dout == din);
    end
    if (en && shift_req && !dir_right) begin
      assert_up_body_R3: assert (dout[WIDTH-1:1] == din[WIDTH-2:0]);
      assert_up_fill_R5: assert (dout[0] == fill_lo);
    end
    if (en && shift_req && dir_right) begin
      assert_down_body_R4: assert (dout[WIDTH-2:0] == din[WIDTH-1:1]);
      assert_down_fill_R6: assert (dout[WIDTH-1] == fill_hi);
    end
  end

  initial begin
    assert_width_min_R9: assert (WIDTH >= 2);
  end

endmodule

// File: tb/shift1_fill_bench.sv
`timescale 1ns/1ps
module shift1_fill_bench;

  localparam int W = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] din = '0;
  logic         fill_lo = 0, fill_hi = 0, shift_req = 0, dir_right = 0, en = 0;
  logic [W-1:0] dout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shift1_fill #(.WIDTH(W)) u_shift1_fill (
    .din(din), .fill_lo(fill_lo), .fill_hi(fill_hi),
    .shift_req(shift_req), .dir_right(dir_right), .en(en), .dout(dout)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic flo, input logic fhi,
                                         input logic s, input logic r, input logic e);
    logic [W-1:0] res;
    res = '0;
    if (e) begin
      for (int i = 0; i < W; i++) begin
        if (!s)      res[i] = d[i];
        else if (!r) res[i] = (i == 0)     ? flo : d[i-1];
        else         res[i] = (i == W - 1) ? fhi : d[i+1];
      end
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h (din=%h flo=%b fhi=%b s=%b r=%b en=%b)",
               tag, dout, exp, din, fill_lo, fill_hi, shift_req, dir_right, en);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic flo, input logic fhi,
                       input logic s, input logic r, input logic e);
    @(negedge clk);
    din = d; fill_lo = flo; fill_hi = fhi; shift_req = s; dir_right = r; en = e;
    #1;
  endtask

  // R1: disabled output is zero
  task automatic test_disabled();
    apply(8'hFF, 1, 1, 1, 1, 0); check("R1", 8'h00);
    apply(8'hA5, 1, 0, 0, 0, 0); check("R1", 8'h00);
  endtask

  // R2: pass-through
  task automatic test_pass();
    apply(8'h3C, 1, 1, 0, 1, 1); check("R2", 8'h3C);
    apply(8'h81, 0, 0, 0, 0, 1); check("R2", 8'h81);
  endtask

  // R3, R5: shift toward higher indices
  task automatic test_up();
    apply(8'h81, 0, 1, 1, 0, 1); check("R3", 8'h02);
    apply(8'h40, 1, 0, 1, 0, 1); check("R5", 8'h81);
  endtask

  // R4, R6: shift toward lower indices
  task automatic test_down();
    apply(8'h81, 1, 0, 1, 1, 1); check("R4", 8'h40);
    apply(8'h02, 0, 1, 1, 1, 1); check("R6", 8'h81);
  endtask

  // R7: unused fill bits have no effect
  task automatic test_fill_ignored();
    apply(8'h5A, 0, 0, 1, 0, 1); check("R7", 8'hB4);
    apply(8'h5A, 0, 1, 1, 0, 1); check("R7", 8'hB4);
    apply(8'h5A, 0, 0, 1, 1, 1); check("R7", 8'h2D);
    apply(8'h5A, 1, 0, 1, 1, 1); check("R7", 8'h2D);
    apply(8'h5A, 1, 1, 0, 0, 1); check("R7", 8'h5A);
    apply(8'h5A, 1, 1, 1, 0, 0); check("R7", 8'h00);
  endtask

  // R8: output follows inputs without a clock edge
  task automatic test_comb();
    apply(8'h0F, 0, 0, 0, 0, 1); check("R8", 8'h0F);
    din = 8'hF0; #1; check("R8", 8'hF0);
    en = 0; #1; check("R8", 8'h00);
  endtask

  // R9 default width, plus exhaustive sweep of R1..R7
  task automatic test_exhaustive();
    for (int v = 0; v < (1 << W); v++) begin
      for (int f = 0; f < 4; f++) begin
        for (int c = 0; c < 8; c++) begin
          string tag;
          apply(v[W-1:0], f[0], f[1], c[1], c[2], c[0]);
          if (!c[0])      tag = "R1";
          else if (!c[1]) tag = "R2";
          else if (!c[2]) tag = "R3/R5";
          else            tag = "R4/R6";
          check(tag, model(v[W-1:0], f[0], f[1], c[1], c[2], c[0]));
        end
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1;
    #1;
    check("R1", 8'h00);
    test_disabled();
    test_pass();
    test_up();
    test_down();
    test_fill_ignored();
    test_comb();
    test_exhaustive();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule